// File: doc/BRIEF.md
# Lock-Guarded Debug Cycle Counter

This block is a small register file for a debug and trace unit. Its main content is a free-running cycle counter used to profile code. A software lock protects the counter and its control bit, so that stray stores from the program under debug cannot stop or corrupt it. Each bus access carries a sideband flag that says where it comes from. An access flagged as external comes from a debugger and is never subject to the lock. An access flagged as internal comes from software on the processor. Internal software must write a fixed 32-bit key before its writes take effect, and it should relock the block afterwards.

Register offsets on the APB-style bus are as follows. 0x0 is the control register, with the count enable in bit 0. 0x4 is the 32-bit count. 0x8 is the key register, which is write-only. 0xC is the lock status register. A write is performed in the cycle where `psel` and `penable` are both high. Read data is combinational from `paddr`. The lock is a two-state machine. Its states are `LK_SHUT` (locked, and the reset state) and `LK_OPEN` (unlocked). There are two transitions. *unlock* goes from `LK_SHUT` to `LK_OPEN` on a key-register write of 0xC5ACCE55. *relock* goes from `LK_OPEN` to `LK_SHUT` on a key-register write of any other value. A key-register write that matches neither transition leaves the state unchanged. Key-register writes from either source drive these transitions. The parameter `LOCK_IMPL` set to 0 removes the machine, and the block then behaves as if it were always open.

Top module: `dbg_cyc_lock`

## Requirements
- R1: After reset, the block is in `LK_SHUT`, the control register reads 0, the count reads 0, and an internal read of the status register returns 0x3.
- R2: A write of 0xC5ACCE55 to the key register (offset 0x8) unlocks the block. Internal status reads then return 0x1, where bit 0 means the lock is implemented and bit 1 means the block is locked.
- R3: A write of any other value to the key register relocks the block, so internal status reads return 0x3 again.
- R4: While the block is locked, internal writes to the control and count registers have no effect. Reads of those registers are still served.
- R5: Writes flagged external (`pext`=1) take effect whatever the lock state.
- R6: An external read of the status register returns 0.
- R7: The count increments by one per clock only while control bit 0 is 1 and `trace_en` is 1. Otherwise it holds.
- R8: A permitted write to the count register takes priority over an increment in the same cycle.
- R9: The count wraps from 0xFFFFFFFF to 0 without raising any flag.
- R10: The key register always reads as 0.
- R11: With `LOCK_IMPL`=0, the status register reads 0 and internal writes always take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Global trace enable; gates counting |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [3:2] select the register |
| pwdata | input | DATA_W | Write data |
| pext | input | 1 | 1 = external (debugger) access, 0 = internal software |
| prdata | output | DATA_W | Read data for the addressed register |

## Verification
The bench drives the lock through three key-register patterns: the correct key, a key that differs from it by one bit, and relocking after use. This separates a full 32-bit compare from a partial one. Writes to the control and count registers are repeated from both sources while the block is locked and while it is open, which shows whether the lock gate respects the source flag. The counter is run with the enable bit and `trace_en` in each combination, and is then loaded near the top of its range to expose the wrap. One load is made while the counter is running, which shows whether the load or the increment wins. A second instance with the lock removed receives the same stimulus, so that the lock path and the lock-free path can be compared.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_KEY   = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_e;

endpackage

// File: rtl/dcc_lock_fsm.sv
module dcc_lock_fsm
    import dcc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              locked
);

    lock_state_e state_q, state_d;
    logic        key_ok;

    assign key_ok = (key_data == DATA_W'(UNLOCK_KEY));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_wr && key_ok)  state_d = LK_OPEN;
            LK_OPEN: if (key_wr && !key_ok) state_d = LK_SHUT;
        endcase
    end

    always_comb begin
        locked = (state_q == LK_SHUT);
    end

    assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == DATA_W'(UNLOCK_KEY)) |=> !locked);

    assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != DATA_W'(UNLOCK_KEY)) |=> locked);

    assert_hold_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(locked));

endmodule

// File: rtl/dcc_counter.sv
module dcc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (run)  cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && count != CNT_MAX) |=> count == $past(count) + 1'b1);

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && count == CNT_MAX) |=> count == '0);

endmodule

// File: rtl/dbg_cyc_lock.sv
module dbg_cyc_lock
    import dcc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter bit LOCK_IMPL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              pext,
    output logic [DATA_W-1:0] prdata
);

    reg_sel_e sel;
    logic     wr_any, wr_ok, locked, ctrl_en;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] stat_word;
    logic     unused_addr;

    assign sel         = reg_sel_e'(paddr[3:2]);
    assign unused_addr = ^paddr[1:0];
    assign wr_any      = psel && penable && pwrite;
    assign wr_ok       = wr_any && (pext || !locked);

    generate
        if (LOCK_IMPL) begin : g_lock
            dcc_lock_fsm #(.DATA_W(DATA_W)) u_lock (
                .clk      (clk),
                .rst_n    (rst_n),
                .key_wr   (wr_any && sel == REG_KEY),
                .key_data (pwdata),
                .locked   (locked)
            );
            assign stat_word = {{(DATA_W-2){1'b0}}, locked, 1'b1};
        end else begin : g_nolock
            assign locked    = 1'b0;
            assign stat_word = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ctrl_en <= 1'b0;
        else if (wr_ok && sel == REG_CTRL)   ctrl_en <= pwdata[0];
    end

    dcc_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_en && trace_en),
        .load     (wr_ok && sel == REG_COUNT),
        .load_val (pwdata),
        .count    (count)
    );

    always_comb begin
        prdata = '0;
        unique case (sel)
            REG_CTRL:  prdata = {{(DATA_W-1){1'b0}}, ctrl_en};
            REG_COUNT: prdata = count;
            REG_KEY:   prdata = '0;
            REG_STAT:  prdata = pext ? '0 : stat_word;
        endcase
    end

    assert_shut_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !pext && locked && sel == REG_CTRL) |=> $stable(ctrl_en));

    assert_ext_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && pext && sel == REG_CTRL) |=> ctrl_en == $past(pwdata[0]));

    assert_ext_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && pext && sel == REG_STAT) |-> prdata == '0);

    assert_key_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && sel == REG_KEY) |-> prdata == '0);

endmodule

// File: tb/tb_dbg_cyc_lock.sv
module tb_dbg_cyc_lock;

    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pext = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, prdata_nl;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    dbg_cyc_lock #(.LOCK_IMPL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .pext(pext), .prdata(prdata));

    dbg_cyc_lock #(.LOCK_IMPL(1'b0)) dut_nl (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .pext(pext), .prdata(prdata_nl));

    // Behavioural reference: m_* for the locked unit, n_* for the lock-free unit
    bit          m_locked, m_en, n_en;
    logic [31:0] m_cnt, n_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_locked = 1'b1; m_en = 1'b0; n_en = 1'b0; m_cnt = 0; n_cnt = 0;
        end else begin
            bit wr, ok;
            wr = psel && penable && pwrite;
            ok = pext || !m_locked;
            if (wr && ok && paddr == 4'h4) m_cnt = pwdata;
            else if (m_en && trace_en) m_cnt = m_cnt + 1;
            if (wr && paddr == 4'h4) n_cnt = pwdata;
            else if (n_en && trace_en) n_cnt = n_cnt + 1;
            if (wr && ok && paddr == 4'h0) m_en = pwdata[0];
            if (wr && paddr == 4'h0) n_en = pwdata[0];
            if (wr && paddr == 4'h8) m_locked = (pwdata != KEY);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [3:0] a, input bit ext, input bit nl);
        case (a)
            4'h0: return nl ? {31'b0, n_en} : {31'b0, m_en};
            4'h4: return nl ? n_cnt : m_cnt;
            4'h8: return 32'h0;
            default: return (ext || nl) ? 32'h0 : {30'b0, m_locked, 1'b1};
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a, input bit ext);
        case (a)
            4'h0: return "R4 ctrl";
            4'h4: return "R7 count";
            4'h8: return "R10 key";
            default: return ext ? "R6 stat" : "R2 stat";
        endcase
    endfunction

    task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                       input bit ext, output logic [31:0] r, output logic [31:0] rn);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pext = ext;
        @(negedge clk);
        penable = 1'b1;
        r = prdata; rn = prdata_nl;
        if (!wr) begin
            chk(tag_of(a, ext), r, model_rd(a, ext, 1'b0));
            chk("R11 lockfree", rn, model_rd(a, ext, 1'b1));
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        logic [31:0] r, rn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus(0, 4'hC, 0, 0, r, rn); chk("R1 stat", r, 32'h3);
        bus(0, 4'h0, 0, 0, r, rn); chk("R1 ctrl", r, 32'h0);
        bus(0, 4'h4, 0, 0, r, rn); chk("R1 count", r, 32'h0);

        // R4 locked internal writes ignored; R11 lock-free unit accepts them
        bus(1, 4'h0, 32'h1, 0, r, rn);
        bus(1, 4'h4, 32'h1234, 0, r, rn);
        bus(0, 4'h0, 0, 0, r, rn); chk("R4 ctrl", r, 32'h0); chk("R11 ctrl", rn, 32'h1);
        bus(0, 4'h4, 0, 0, r, rn); chk("R4 count", r, 32'h0);
        bus(0, 4'hC, 0, 0, r, rn); chk("R11 stat", rn, 32'h0);

        // R3 near-miss key keeps it locked
        bus(1, 4'h8, KEY ^ 32'h1, 0, r, rn);
        bus(0, 4'hC, 0, 0, r, rn); chk("R3 stat", r, 32'h3);

        // R6 external status read
        bus(0, 4'hC, 0, 1, r, rn); chk("R6 stat", r, 32'h0);

        // R5 external writes bypass lock; R7 no counting while trace_en low
        bus(1, 4'h4, 32'd100, 1, r, rn);
        bus(1, 4'h0, 32'h1, 1, r, rn);
        repeat (4) @(negedge clk);
        bus(0, 4'h4, 0, 1, r, rn); chk("R5 R7 count", r, 32'd100);

        // R7 counting with enable and trace_en
        trace_en = 1'b1;
        repeat (5) @(negedge clk);
        bus(0, 4'h4, 0, 0, r, rn);
        bus(0, 4'h0, 0, 0, r, rn); chk("R5 ctrl", r, 32'h1);

        // R2 unlock, R10 key reads zero
        bus(1, 4'h8, KEY, 0, r, rn);
        bus(0, 4'hC, 0, 0, r, rn); chk("R2 stat", r, 32'h1);
        bus(0, 4'h8, 0, 0, r, rn); chk("R10 key", r, 32'h0);

        // R8 load beats increment: trace_en high during the write edge
        bus(1, 4'h4, 32'd5, 0, r, rn);
        trace_en = 1'b0;
        bus(0, 4'h4, 0, 0, r, rn); chk("R8 count", r, 32'd5);

        // R9 wrap
        bus(1, 4'h4, 32'hFFFF_FFFF, 0, r, rn);
        @(negedge clk); trace_en = 1'b1;
        @(negedge clk); trace_en = 1'b0;
        bus(0, 4'h4, 0, 0, r, rn); chk("R9 count", r, 32'h0);
        bus(1, 4'h4, 32'hFFFF_FFFD, 0, r, rn);
        trace_en = 1'b1;
        repeat (6) bus(0, 4'h4, 0, 0, r, rn);
        trace_en = 1'b0;

        // R4 open: internal ctrl write now accepted
        bus(1, 4'h0, 32'h0, 0, r, rn);
        bus(0, 4'h0, 0, 0, r, rn); chk("R4 open ctrl", r, 32'h0);

        // R3 relock then internal write ignored again
        bus(1, 4'h8, 32'h0, 0, r, rn);
        bus(0, 4'hC, 0, 0, r, rn); chk("R3 relock", r, 32'h3);
        bus(1, 4'h0, 32'h1, 0, r, rn);
        bus(0, 4'h0, 0, 0, r, rn); chk("R4 relocked ctrl", r, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule